// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block gives a host a way to read a fixed set of read-only configuration items using two registers. A 16-bit key written to the selector picks one item and rewinds a read pointer to the item's first byte. Each read of the data register then returns the next bytes of that item and moves the pointer past them. The item contents sit in a small ROM inside the block, which is computed from the item's bank and index. One key bit picks between two banks of items that share the same index range. Keys whose index is outside the configured range leave the port in an invalid state, and that state reads as zero.

Selector and data share one narrow port. Offset 0 takes 2-byte selector writes, and reads at either offset stream item data. A read carries a size code for 1, 2, 4 or 8 bytes. The returned bytes are right-justified in the data bus, with the earliest item byte in the most significant position, and the low positions are filled with zeros once the item is exhausted. Accesses of a size the port does not take are dropped and set a sticky error flag, which only reset clears.

Top module: `cfgport_top`

## Requirements
- R1: Reset is synchronous and active low. After reset, rd_valid and size_err are 0, and the selection is bank 0, index 0 (the signature item) at offset 0. That item is 4 bytes long and holds 0x51, 0x45, 0x4D, 0x55.
- R2: An accepted 2-byte write at offset 0 (acc_addr = 0) takes acc_wdata[15:0] as the new key and resets the read offset to 0.
- R3: Key bit 15 selects bank 1 when set. Key bits [13:0] form the item index, and key bit 14 has no effect. An index at or above NUM_ENTRIES (default 8) makes the selection invalid.
- R4: Item (bank b, index i) other than the signature has length (i + 5*b) mod (ITEM_BYTES+1), with ITEM_BYTES defaulting to 11. Its byte k is ((16*i + k) mod 256) XOR (0x80 if b = 1, else 0).
- R5: A read with size code s (0, 1, 2, 3 meaning N = 1, 2, 4, 8 bytes) returns N item bytes from the current offset in rd_data[8N-1:0], the first byte most significant. Bits above 8N are zero. The offset advances by the number of item bytes delivered.
- R6: When fewer than N bytes remain, the remaining bytes fill the high positions and the lower positions read as zero.
- R7: A read with an invalid selection, an empty item, or an offset at the item length returns zero and leaves the offset unchanged.
- R8: Accepted writes other than a 2-byte write at offset 0 (1-byte writes at either offset, 2-byte writes at offset 1) change neither the selection nor the offset.
- R9: Writes are accepted only with size code 0 or 1. Reads are accepted with any size code when WIDE_READS = 1 (the default), and only with code 0 otherwise. An access that is not accepted has no effect on the selection or the offset, and a rejected read returns zero. Any access that is not accepted sets size_err, which stays at 1 until reset.
- R10: rd_valid is 1 in the cycle after every read, accepted or not, with rd_data registered alongside it. rd_valid is 0 after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | Port offset: 0 selector, 1 data |
| acc_size | input | 2 | Size code: 0/1/2/3 = 1/2/4/8 bytes |
| acc_wdata | input | 16 | Write data; key on selector writes |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 64 | Read response, right-justified bytes |
| size_err | output | 1 | Sticky flag for unaccepted access sizes |

## Verification
The streaming path is driven with every read width. The widths are run against items whose remaining length is larger than, equal to and smaller than the request, which separates correct byte order from zero-padding and from pointer advance errors. A bank-1 key, a key with the ignored bit set, the empty item, and out-of-range indices at the boundary and at the top of the index field show whether the key decode splits bank, index and validity correctly. Ignored and rejected writes are each followed by a read that continues the stream. Any change to the selection or the offset therefore shows up at the data output.

// File: rtl/cfgport_pkg.sv
// Shared definitions for the keyed configuration read port.
// Holds the key layout, access size codes and the functions that
// compute item lengths and contents for the internal ROM.
package cfgport_pkg;

    localparam int KEY_W     = 16;
    localparam int BANK_BIT  = 15;
    localparam int KEYIDX_W  = 14;
    localparam int LANES     = 8;
    localparam logic [31:0] SIG_WORD = 32'h5145_4D55;

    typedef enum logic [1:0] {
        SZ_1 = 2'd0,
        SZ_2 = 2'd1,
        SZ_4 = 2'd2,
        SZ_8 = 2'd3
    } acc_size_e;

    // Length in bytes of item (bank, idx); signature item is fixed at 4.
    function automatic int unsigned item_len(logic bank, int unsigned idx,
                                             int unsigned max_bytes);
        if (!bank && idx == 0) return 4;
        return (idx + (bank ? 5 : 0)) % (max_bytes + 1);
    endfunction

    // Byte k of item (bank, idx).
    function automatic logic [7:0] item_byte(logic bank, int unsigned idx,
                                             int unsigned k);
        logic [7:0] b;
        if (!bank && idx == 0) begin
            b = (k < 4) ? SIG_WORD[8*(3-k) +: 8] : 8'h00;
        end else begin
            b = 8'((idx * 16 + k) % 256) ^ (bank ? 8'h80 : 8'h00);
        end
        return b;
    endfunction

endpackage

// File: rtl/cfgport_key_decode.sv
// Splits a 16-bit key into bank flag and item index and checks the
// index against the configured entry count.
// Assumes NUM_ENTRIES fits in the 14-bit index field.
module cfgport_key_decode
    import cfgport_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_SEL_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [KEY_W-1:0]     key,
    output logic                 bank,
    output logic [IDX_SEL_W-1:0] idx,
    output logic                 valid
);

    logic unused_key_bit;

    // Field split and range check of the raw key.
    always_comb begin
        bank  = key[BANK_BIT];
        idx   = key[IDX_SEL_W-1:0];
        valid = key[KEYIDX_W-1:0] < KEYIDX_W'(NUM_ENTRIES);
    end

    assign unused_key_bit = key[KEYIDX_W];

endmodule

// File: rtl/cfgport_item_rom.sv
// Computed item store: returns the length of the selected item and the
// bytes at offset..offset+LANES-1, each with an in-range flag.
// Assumes bank/idx come from a registered selection.
module cfgport_item_rom
    import cfgport_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int ITEM_BYTES  = 11,
    localparam int IDX_SEL_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int OFF_W      = $clog2(ITEM_BYTES + 1)
) (
    input  logic                  bank,
    input  logic [IDX_SEL_W-1:0]  idx,
    input  logic [OFF_W-1:0]      offset,
    output logic [LANES-1:0][7:0] lane_byte,
    output logic [LANES-1:0]      lane_in
);

    logic [OFF_W-1:0] len;

    // Length lookup for the selected item.
    always_comb begin
        len = OFF_W'(item_len(bank, int'(idx), ITEM_BYTES));
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        // Byte j past the offset and whether it lies inside the item.
        always_comb begin
            lane_in[j]   = (int'(offset) + j) < int'(len);
            lane_byte[j] = item_byte(bank, int'(idx), int'(offset) + j);
        end
    end

endmodule

// File: rtl/cfgport_packer.sv
// Packs the first N in-range lane bytes into the low 8N bits of the
// read word, earliest byte most significant, zeros elsewhere.
// Assumes lane_in is a prefix (once a lane is out, all later ones are).
module cfgport_packer
    import cfgport_pkg::*;
#(
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic [1:0]            size,
    input  logic [LANES-1:0][7:0] lane_byte,
    input  logic [LANES-1:0]      lane_in,
    output logic [8*LANES-1:0]    data,
    output logic [CNT_W-1:0]      count
);

    // Byte placement and count of delivered bytes.
    always_comb begin
        int nsz;
        nsz   = 1 << size;
        data  = '0;
        count = '0;
        for (int j = 0; j < LANES; j++) begin
            if (j < nsz && lane_in[j]) begin
                data[8*(nsz-1-j) +: 8] = lane_byte[j];
                count = count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/cfgport_top.sv
// Keyed configuration read port. A 2-byte write at offset 0 selects an
// item; reads stream its bytes. Unaccepted sizes set a sticky flag.
// Assumes one access per acc_valid pulse; responses one cycle later.
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int ITEM_BYTES  = 11,
    parameter bit WIDE_READS  = 1'b1,
    localparam int IDX_SEL_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int OFF_W      = $clog2(ITEM_BYTES + 1),
    localparam int CNT_W      = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic                  acc_addr,
    input  logic [1:0]            acc_size,
    input  logic [KEY_W-1:0]      acc_wdata,
    output logic                  rd_valid,
    output logic [8*LANES-1:0]    rd_data,
    output logic                  size_err
);

    logic                  cur_bank;
    logic [IDX_SEL_W-1:0]  cur_idx;
    logic                  cur_ok;
    logic [OFF_W-1:0]      cur_off;

    logic                  key_bank;
    logic [IDX_SEL_W-1:0]  key_idx;
    logic                  key_ok;

    logic [LANES-1:0][7:0] lane_byte;
    logic [LANES-1:0]      lane_in;
    logic [8*LANES-1:0]    pk_data;
    logic [CNT_W-1:0]      pk_count;

    logic                  accept;
    logic                  do_sel;
    logic                  do_read;

    cfgport_key_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_dec (
        .key   (acc_wdata),
        .bank  (key_bank),
        .idx   (key_idx),
        .valid (key_ok)
    );

    cfgport_item_rom #(.NUM_ENTRIES(NUM_ENTRIES), .ITEM_BYTES(ITEM_BYTES)) u_rom (
        .bank      (cur_bank),
        .idx       (cur_idx),
        .offset    (cur_off),
        .lane_byte (lane_byte),
        .lane_in   (lane_in)
    );

    cfgport_packer u_pack (
        .size      (acc_size),
        .lane_byte (lane_byte),
        .lane_in   (lane_in),
        .data      (pk_data),
        .count     (pk_count)
    );

    // Access size acceptance and the two effective operations.
    always_comb begin
        if (acc_write) accept = (acc_size == SZ_1) || (acc_size == SZ_2);
        else           accept = WIDE_READS || (acc_size == SZ_1);
        do_sel  = acc_valid && acc_write && accept && (acc_size == SZ_2) && !acc_addr;
        do_read = acc_valid && !acc_write && accept;
    end

    // Selection and read offset state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_bank <= 1'b0;
            cur_idx  <= '0;
            cur_ok   <= 1'b1;
            cur_off  <= '0;
        end else if (do_sel) begin
            cur_bank <= key_bank;
            cur_idx  <= key_idx;
            cur_ok   <= key_ok;
            cur_off  <= '0;
        end else if (do_read && cur_ok) begin
            cur_off  <= cur_off + OFF_W'(pk_count);
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_valid && !acc_write;
            rd_data  <= (do_read && cur_ok) ? pk_data : '0;
        end
    end

    // Sticky flag for accesses of a size the port does not take.
    always_ff @(posedge clk) begin
        if (!rst_n)                    size_err <= 1'b0;
        else if (acc_valid && !accept) size_err <= 1'b1;
    end

endmodule

// File: rtl/cfgport_checker.sv
// Port-level properties of the keyed configuration read port.
module cfgport_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [1:0]  acc_size,
    input logic        rd_valid,
    input logic [63:0] rd_data,
    input logic        size_err
);

    p_read_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> rd_valid);

    p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write |=> !rd_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rd_valid);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |=> size_err);

    p_wide_write_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && acc_size[1] |=> size_err);

    p_byte_read_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && acc_size == 2'd0 |=> rd_data[63:8] == '0);

    p_half_read_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && acc_size == 2'd1 |=> rd_data[63:16] == '0);

endmodule

bind cfgport_top cfgport_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_size  (acc_size),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .size_err  (size_err)
);

// File: tb/tb_cfgport_top.sv
module tb_cfgport_top;

    localparam int NE = 8;
    localparam int IB = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_addr = 1'b0;
    logic [1:0]  acc_size = 2'd0;
    logic [15:0] acc_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        size_err;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference selection state, kept from the requirements.
    logic m_bank;
    int   m_idx;
    logic m_ok;
    int   m_off;

    cfgport_top dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .size_err(size_err)
    );

    always #10 clk = ~clk;

    function automatic int blen(logic b, int i);
        if (!b && i == 0) return 4;
        return (i + (b ? 5 : 0)) % (IB + 1);
    endfunction

    function automatic logic [7:0] bbyte(logic b, int i, int k);
        logic [31:0] sig = 32'h5145_4D55;
        if (!b && i == 0) return sig[8*(3-k) +: 8];
        return 8'((16*i + k) % 256) ^ (b ? 8'h80 : 8'h00);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access cycle; outputs sampled at the following falling edge.
    task automatic access(logic wr, logic addr, logic [1:0] sz, logic [15:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = addr;
        acc_size = sz; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_bank = 1'b0; m_idx = 0; m_ok = 1'b1; m_off = 0;
    endtask

    task automatic select(logic [15:0] key);
        access(1'b1, 1'b0, 2'd1, key);
        m_bank = key[15];
        m_idx  = int'(key[13:0]);
        m_ok   = m_idx < NE;
        m_off  = 0;
    endtask

    task automatic read_chk(string req, logic [1:0] sz);
        logic [63:0] exp = '0;
        int n = 1 << sz;
        for (int j = 0; j < n; j++) begin
            exp = exp << 8;
            if (m_ok && m_off < blen(m_bank, m_idx)) begin
                exp[7:0] = bbyte(m_bank, m_idx, m_off);
                m_off++;
            end
        end
        access(1'b0, 1'b1, sz, 16'h0);
        check({req, " rd_valid"}, 64'(rd_valid), 64'd1);
        check(req, rd_data, exp);
    endtask

    task automatic t_reset();
        check("R1 rd_valid after reset", 64'(rd_valid), 64'd0);
        check("R1 size_err after reset", 64'(size_err), 64'd0);
        read_chk("R1 signature high half", 2'd1);
        check("R1 signature literal", rd_data, 64'h5145);
        read_chk("R1 signature low half", 2'd1);
        check("R1 signature literal low", rd_data, 64'h4D55);
        read_chk("R7 read past end", 2'd0);
    endtask

    task automatic t_pad();
        select(16'h0003);
        read_chk("R2 R5 two-byte read", 2'd1);
        check("R4 item 3 bytes", rd_data, 64'h3031);
        read_chk("R6 padded tail", 2'd1);
        check("R6 padded literal", rd_data, 64'h3200);
        read_chk("R7 at length", 2'd0);
    endtask

    task automatic t_bank();
        select(16'h8006);
        read_chk("R3 R5 bank1 eight bytes", 2'd3);
        check("R4 bank1 literal", rd_data, 64'hE0E1E2E3E4E5E6E7);
        read_chk("R6 bank1 four-byte tail", 2'd2);
        check("R6 bank1 tail literal", rd_data, 64'hE8E9EA00);
    endtask

    task automatic t_empty_invalid();
        select(16'h8007);
        read_chk("R7 empty item", 2'd1);
        select(16'h0008);
        read_chk("R3 R7 index at limit", 2'd3);
        select(16'h3FFF);
        read_chk("R3 R7 top index", 2'd2);
    endtask

    task automatic t_flag_bit();
        select(16'h4003);
        read_chk("R3 bit14 ignored", 2'd2);
        check("R3 bit14 literal", rd_data, 64'h30313200);
    endtask

    task automatic t_data_write();
        select(16'h0005);
        read_chk("R5 first byte", 2'd0);
        access(1'b1, 1'b1, 2'd0, 16'h00FF);
        check("R10 no response to write", 64'(rd_valid), 64'd0);
        access(1'b1, 1'b0, 2'd0, 16'h0001);
        access(1'b1, 1'b1, 2'd1, 16'h0001);
        read_chk("R8 stream continues after ignored writes", 2'd1);
        check("R8 literal", rd_data, 64'h5152);
        check("R8 no error", 64'(size_err), 64'd0);
    endtask

    task automatic t_reject();
        access(1'b1, 1'b0, 2'd2, 16'h0001);
        check("R9 flag on 4-byte write", 64'(size_err), 64'd1);
        read_chk("R9 rejected write left selection", 2'd1);
        check("R9 literal", rd_data, 64'h5354);
        access(1'b1, 1'b0, 2'd3, 16'h0002);
        select(16'h0001);
        read_chk("R9 R2 reselect after reject", 2'd2);
        check("R9 flag stays set", 64'(size_err), 64'd1);
    endtask

    task automatic t_reset_mid();
        select(16'h0007);
        read_chk("R5 before reset", 2'd0);
        do_reset();
        check("R1 flag cleared", 64'(size_err), 64'd0);
        read_chk("R1 signature after reset", 2'd2);
        check("R1 signature word", rd_data, 64'h51454D55);
    endtask

    initial begin
        #(20 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_pad();
        t_bank();
        t_empty_invalid();
        t_flag_bit();
        t_data_write();
        t_reject();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule